// File: doc/BRIEF.md
# Dual-Mode Period / Free-Running Timer

This block is a counter that works in one of two ways, picked by a single mode input. In the narrow mode the low byte counts up and is compared against a period value. The high byte holds that period, and a shadow copy of it is what the comparator actually uses. In the wide mode the two bytes join into one counter of twice the width. That counter runs freely and wraps to zero.

Counting advances only on cycles where the clock-source tick is high and the run enable is set. The tick is either a one-cycle strobe that is already synchronous, or an asynchronous level that passes through a two-flop synchronizer and a rising-edge detector. A compile-time parameter chooses between the two. Software reaches the two bytes through a small write/read port. In the wide mode the high byte is reached through buffers: writes to it are staged in a write buffer, and a low-byte read freezes the high byte in a read buffer. This keeps a two-access read coherent. Each period match and each wide wrap raises a one-cycle event output.

Top module: `dual_timer`

## Requirements
- R1: `wide_mode` = 0 selects narrow operation and `wide_mode` = 1 selects wide operation. In narrow mode the upper half of `count_out` reads zero and the lower half is the low byte. In wide mode `count_out` is {high byte, low byte}.
- R2: In narrow mode the low byte rises by one on each tick cycle while `run_en` = 1, and it holds when there is no tick or when `run_en` = 0. A low-byte write (`reg_sel` = 0) loads the low byte directly and takes priority over a tick in the same cycle.
- R3: In narrow mode, a tick while enabled with the low byte equal to the shadow period clears the low byte to zero and copies the current period register into the shadow.
- R4: A narrow-mode high-byte write (`reg_sel` = 1) changes the period register only. While `run_en` = 1, the new value takes effect after the next match. While `run_en` = 0, the shadow follows the period register one cycle later.
- R5: In wide mode the full count rises by one on each enabled tick and wraps from all ones to zero.
- R6: `event_pulse` is high for exactly the cycle after an enabled tick that caused a narrow match or a wide wrap, and is low otherwise.
- R7: In wide mode with `run_en` = 1, all writes are ignored. Neither the count nor the high-byte write buffer changes.
- R8: In wide mode with `run_en` = 0, a high-byte write goes only to the write buffer. A low-byte write loads the full count as {write buffer, written data}.
- R9: In wide mode, a low-byte read (`rd_en` = 1, `reg_sel` = 0) returns the live low byte and latches the current high byte into a read buffer. A high-byte read returns that buffer.
- R10: In narrow mode a high-byte read returns the period register and a low-byte read returns the live low byte. `rd_data` is combinational in `reg_sel`.
- R11: With `SYNC_EDGE` = 1, each rising edge of `clk_src` advances the count once, on the third rising clock edge after the level rises. A level held high does not count again.
- R12: Synchronous active-high reset clears the count, the period, the shadow, both buffers and `event_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_src | input | 1 | Count source: synchronous tick, or asynchronous level when SYNC_EDGE = 1 |
| run_en | input | 1 | Counting enable |
| wide_mode | input | 1 | 0 narrow period mode, 1 wide free-running mode |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives the high-byte latch) |
| reg_sel | input | 1 | 0 low byte, 1 high byte |
| wr_data | input | HALF_W | Write data |
| rd_data | output | HALF_W | Read data for the selected byte |
| count_out | output | 2*HALF_W | Live count view |
| event_pulse | output | 1 | One-cycle match / wrap event |

## Verification
The bench builds two instances. The first uses `HALF_W` = 8 with `SYNC_EDGE` = 0, so the tick is controlled cycle by cycle. It reaches the 16-bit wrap through a preload that sits just below all ones. The second uses `HALF_W` = 4 with `SYNC_EDGE` = 1. Its narrow count width brings the 8-bit wide wrap within a few edges of a preload, and it exposes the synchronizer latency and the single-count-per-edge behaviour at the ports.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    typedef enum logic {
        SEL_LOW  = 1'b0,
        SEL_HIGH = 1'b1
    } byte_sel_e;

    typedef enum logic {
        MODE_NARROW = 1'b0,
        MODE_WIDE   = 1'b1
    } tmr_mode_e;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_LOW   = 2'd1,
        ACC_HIGH  = 2'd2
    } acc_kind_e;

    function automatic acc_kind_e decode_acc(input logic strobe, input byte_sel_e sel);
        if (!strobe)           return ACC_NONE;
        else if (sel == SEL_LOW) return ACC_LOW;
        else                   return ACC_HIGH;
    endfunction

endpackage

// File: rtl/dtmr_tick_src.sv
module dtmr_tick_src #(
    parameter bit SYNC_EDGE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic src,
    output logic tick
);
    generate
        if (SYNC_EDGE) begin : g_sync
            localparam int STAGES = 3;
            logic [STAGES-1:0] sh_q;

            always_ff @(posedge clk) begin
                if (rst) sh_q <= '0;
                else     sh_q <= {sh_q[STAGES-2:0], src};
            end

            assign tick = sh_q[STAGES-2] & ~sh_q[STAGES-1];

            // R11: an edge yields a single tick
            p_single_tick_r11: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end else begin : g_pass
            logic unused_ok;
            assign unused_ok = clk ^ rst;
            assign tick = src;
        end
    endgenerate
endmodule

// File: rtl/dtmr_hbuf.sv
module dtmr_hbuf
    import dtmr_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  tmr_mode_e         mode,
    input  acc_kind_e         wr_kind,
    input  acc_kind_e         rd_kind,
    input  logic [HALF_W-1:0] wr_data,
    input  logic [HALF_W-1:0] hi_cnt,
    output logic [HALF_W-1:0] wbuf_q,
    output logic [HALF_W-1:0] rbuf_q
);
    logic stage_wr;
    logic latch_rd;

    assign stage_wr = (mode == MODE_WIDE) && !run && (wr_kind == ACC_HIGH);
    assign latch_rd = (mode == MODE_WIDE) && (rd_kind == ACC_LOW);

    always_ff @(posedge clk) begin
        if (rst) begin
            wbuf_q <= '0;
            rbuf_q <= '0;
        end else begin
            if (stage_wr) wbuf_q <= wr_data;
            if (latch_rd) rbuf_q <= hi_cnt;
        end
    end

    // R9: low read freezes the high byte
    p_rbuf_latch_r9: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_WIDE && rd_kind == ACC_LOW) |=> (rbuf_q == $past(hi_cnt)));

    // R7: buffer is frozen while running in wide mode
    p_wbuf_locked_r7: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_WIDE && run) |=> $stable(wbuf_q));
endmodule

// File: rtl/dtmr_core.sv
module dtmr_core
    import dtmr_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              run,
    input  tmr_mode_e         mode,
    input  acc_kind_e         wr_kind,
    input  logic [HALF_W-1:0] wr_data,
    input  logic [HALF_W-1:0] wbuf,
    output logic [HALF_W-1:0] lo_q,
    output logic [HALF_W-1:0] hi_q,
    output logic              evt_q
);
    localparam int FULL_W = 2 * HALF_W;

    logic [HALF_W-1:0] shadow_q;
    logic [FULL_W-1:0] full_cnt;
    logic [FULL_W-1:0] full_nxt;
    logic              adv;
    logic              narrow_hit;
    logic              wide_wrap;

    assign full_cnt   = {hi_q, lo_q};
    assign full_nxt   = full_cnt + FULL_W'(1);
    assign adv        = run && tick;
    assign narrow_hit = (lo_q == shadow_q);
    assign wide_wrap  = &full_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q     <= '0;
            hi_q     <= '0;
            shadow_q <= '0;
            evt_q    <= 1'b0;
        end else begin
            evt_q <= 1'b0;
            if (mode == MODE_NARROW) begin
                if (wr_kind == ACC_LOW) begin
                    lo_q <= wr_data;
                end else if (adv) begin
                    if (narrow_hit) begin
                        lo_q     <= '0;
                        shadow_q <= hi_q;
                        evt_q    <= 1'b1;
                    end else begin
                        lo_q <= lo_q + HALF_W'(1);
                    end
                end
                if (wr_kind == ACC_HIGH) hi_q <= wr_data;
                if (!run) shadow_q <= hi_q;
            end else begin
                if (adv) begin
                    {hi_q, lo_q} <= full_nxt;
                    evt_q        <= wide_wrap;
                end else if (!run && wr_kind == ACC_LOW) begin
                    {hi_q, lo_q} <= {wbuf, wr_data};
                end
            end
        end
    end

    // R6: an event only follows an enabled tick
    p_evt_cause_r6: assert property (@(posedge clk) disable iff (rst)
        evt_q |-> $past(adv));

    // R3: match clears the low byte
    p_match_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_NARROW && adv && wr_kind != ACC_LOW && lo_q == shadow_q)
        |=> (lo_q == '0));

    // R5: wide wrap returns to zero
    p_wide_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_WIDE && adv && (&{hi_q, lo_q})) |=> ({hi_q, lo_q} == '0));

    // R7: running wide counter ignores writes
    p_wide_lock_r7: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_WIDE && run && !tick) |=> ($stable(lo_q) && $stable(hi_q)));

    // R2: idle narrow counter holds
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_NARROW && !run && wr_kind == ACC_NONE) |=> $stable(lo_q));
endmodule

// File: rtl/dual_timer.sv
module dual_timer
    import dtmr_pkg::*;
#(
    parameter int HALF_W    = 8,
    parameter bit SYNC_EDGE = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clk_src,
    input  logic                run_en,
    input  logic                wide_mode,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic                reg_sel,
    input  logic [HALF_W-1:0]   wr_data,
    output logic [HALF_W-1:0]   rd_data,
    output logic [2*HALF_W-1:0] count_out,
    output logic                event_pulse
);
    tmr_mode_e         mode;
    byte_sel_e         sel;
    acc_kind_e         wr_kind;
    acc_kind_e         rd_kind;
    logic              tick;
    logic [HALF_W-1:0] lo_q;
    logic [HALF_W-1:0] hi_q;
    logic [HALF_W-1:0] wbuf_q;
    logic [HALF_W-1:0] rbuf_q;

    assign mode    = tmr_mode_e'(wide_mode);
    assign sel     = byte_sel_e'(reg_sel);
    assign wr_kind = decode_acc(wr_en, sel);
    assign rd_kind = decode_acc(rd_en, sel);

    dtmr_tick_src #(.SYNC_EDGE(SYNC_EDGE)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .src  (clk_src),
        .tick (tick)
    );

    dtmr_hbuf #(.HALF_W(HALF_W)) u_hbuf (
        .clk     (clk),
        .rst     (rst),
        .run     (run_en),
        .mode    (mode),
        .wr_kind (wr_kind),
        .rd_kind (rd_kind),
        .wr_data (wr_data),
        .hi_cnt  (hi_q),
        .wbuf_q  (wbuf_q),
        .rbuf_q  (rbuf_q)
    );

    dtmr_core #(.HALF_W(HALF_W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .run     (run_en),
        .mode    (mode),
        .wr_kind (wr_kind),
        .wr_data (wr_data),
        .wbuf    (wbuf_q),
        .lo_q    (lo_q),
        .hi_q    (hi_q),
        .evt_q   (event_pulse)
    );

    always_comb begin
        if (sel == SEL_LOW)        rd_data = lo_q;
        else if (mode == MODE_WIDE) rd_data = rbuf_q;
        else                        rd_data = hi_q;
    end

    assign count_out = (mode == MODE_WIDE) ? {hi_q, lo_q} : {{HALF_W{1'b0}}, lo_q};

    // R12: reset clears the visible state
    p_reset_clear_r12: assert property (@(posedge clk)
        rst |=> (count_out == '0 && !event_pulse));
endmodule

// File: tb/dual_timer_bench.sv
`timescale 1ns/1ps
module dual_timer_bench;

    typedef struct packed {
        logic        wide;
        logic        run;
        logic        tick;
        logic        wr;
        logic        sel;
        logic [7:0]  data;
        logic [15:0] exp_cnt;
        logic        exp_evt;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 26;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0,1'b0,1'b0,1'b1,1'b1,8'h03,16'h0000,1'b0,4'd4},  // R4 period 3
        '{1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,16'h0000,1'b0,4'd4},  // R4 shadow follows
        '{1'b0,1'b1,1'b1,1'b0,1'b0,8'h00,16'h0001,1'b0,4'd2},  // R2
        '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,16'h0001,1'b0,4'd2},  // R2 no tick
        '{1'b0,1'b1,1'b1,1'b0,1'b0,8'h00,16'h0002,1'b0,4'd2},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,8'h00,16'h0003,1'b0,4'd2},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,8'h00,16'h0000,1'b1,4'd3},  // R3 match
        '{1'b0,1'b1,1'b0,1'b1,1'b1,8'h01,16'h0000,1'b0,4'd4},  // R4 new period 1
        '{1'b0,1'b1,1'b1,1'b0,1'b0,8'h00,16'h0001,1'b0,4'd4},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,8'h00,16'h0002,1'b0,4'd4},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,8'h00,16'h0003,1'b0,4'd4},  // R4 old shadow
        '{1'b0,1'b1,1'b1,1'b0,1'b0,8'h00,16'h0000,1'b1,4'd3},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,8'h00,16'h0001,1'b0,4'd4},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,8'h00,16'h0000,1'b1,4'd6},  // R6
        '{1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,16'h0000,1'b0,4'd2},  // R2 disabled
        '{1'b0,1'b0,1'b0,1'b1,1'b0,8'h05,16'h0005,1'b0,4'd2},  // R2 load
        '{1'b1,1'b0,1'b0,1'b1,1'b1,8'hFF,16'h0105,1'b0,4'd1},  // R1 wide view
        '{1'b1,1'b0,1'b0,1'b1,1'b0,8'hFE,16'hFFFE,1'b0,4'd8},  // R8
        '{1'b1,1'b1,1'b1,1'b0,1'b0,8'h00,16'hFFFF,1'b0,4'd5},  // R5
        '{1'b1,1'b1,1'b0,1'b1,1'b0,8'h12,16'hFFFF,1'b0,4'd7},  // R7
        '{1'b1,1'b1,1'b0,1'b1,1'b1,8'h34,16'hFFFF,1'b0,4'd7},  // R7
        '{1'b1,1'b1,1'b1,1'b0,1'b0,8'h00,16'h0000,1'b1,4'd5},  // R5 wrap
        '{1'b1,1'b1,1'b1,1'b0,1'b0,8'h00,16'h0001,1'b0,4'd6},  // R6 drops
        '{1'b1,1'b0,1'b0,1'b1,1'b0,8'h80,16'hFF80,1'b0,4'd7},  // R7 buffer kept
        '{1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,16'h0080,1'b0,4'd1},  // R1 narrow view
        '{1'b0,1'b1,1'b1,1'b1,1'b0,8'h10,16'h0010,1'b0,4'd2}   // R2 write wins
    };

    logic clk = 1'b0;
    logic rst;
    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic        m_src, m_run, m_wide, m_wr, m_rd, m_sel;
    logic [7:0]  m_wdata, m_rdata;
    logic [15:0] m_cnt;
    logic        m_evt;

    logic        s_src, s_run, s_wide, s_wr, s_rd, s_sel;
    logic [3:0]  s_wdata, s_rdata;
    logic [7:0]  s_cnt;
    logic        s_evt;
    int          s_evt_seen;

    dual_timer #(.HALF_W(8), .SYNC_EDGE(1'b0)) u_dual_timer (
        .clk(clk), .rst(rst), .clk_src(m_src), .run_en(m_run), .wide_mode(m_wide),
        .wr_en(m_wr), .rd_en(m_rd), .reg_sel(m_sel), .wr_data(m_wdata),
        .rd_data(m_rdata), .count_out(m_cnt), .event_pulse(m_evt)
    );

    dual_timer #(.HALF_W(4), .SYNC_EDGE(1'b1)) u_dual_timer_sync (
        .clk(clk), .rst(rst), .clk_src(s_src), .run_en(s_run), .wide_mode(s_wide),
        .wr_en(s_wr), .rd_en(s_rd), .reg_sel(s_sel), .wr_data(s_wdata),
        .rd_data(s_rdata), .count_out(s_cnt), .event_pulse(s_evt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        if (s_evt) s_evt_seen++;
    endtask

    task automatic s_edge();
        s_src = 1'b1;
        repeat (2) cyc();
        s_src = 1'b0;
        repeat (2) cyc();
    endtask

    initial begin
        #(100000ns);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        {m_src, m_run, m_wide, m_wr, m_rd, m_sel} = '0;
        m_wdata = '0;
        {s_src, s_run, s_wide, s_wr, s_rd, s_sel} = '0;
        s_wdata = '0;
        s_evt_seen = 0;
        repeat (3) cyc();
        rst = 1'b0;
        cyc();

        // R12 reset state
        chk("R12 count", 32'(m_cnt), 32'h0);
        chk("R12 event", 32'(m_evt), 32'h0);
        chk("R12 rdata", 32'(m_rdata), 32'h0);
        chk("R12 sync count", 32'(s_cnt), 32'h0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            m_wide  = VEC[i].wide;
            m_run   = VEC[i].run;
            m_src   = VEC[i].tick;
            m_wr    = VEC[i].wr;
            m_sel   = VEC[i].sel;
            m_wdata = VEC[i].data;
            cyc();
            chk($sformatf("R%0d count step %0d", VEC[i].req, i), 32'(m_cnt), 32'(VEC[i].exp_cnt));
            chk($sformatf("R%0d event step %0d", VEC[i].req, i), 32'(m_evt), 32'(VEC[i].exp_evt));
        end
        m_src = 1'b0; m_wr = 1'b0;

        // R8 / R9 coherent read across a carry
        m_wide = 1'b1; m_run = 1'b0;
        m_wr = 1'b1; m_sel = 1'b1; m_wdata = 8'h12; cyc();
        m_sel = 1'b0; m_wdata = 8'hFF; cyc();
        m_wr = 1'b0;
        chk("R8 preload", 32'(m_cnt), 32'h12FF);
        m_run = 1'b1; m_src = 1'b1; m_rd = 1'b1; m_sel = 1'b0;
        #0.5;
        chk("R9 low read", 32'(m_rdata), 32'hFF);
        cyc();
        m_src = 1'b0; m_rd = 1'b0; m_sel = 1'b1;
        #0.5;
        chk("R5 carry", 32'(m_cnt), 32'h1300);
        chk("R9 high read buffered", 32'(m_rdata), 32'h12);

        // R10 narrow reads
        m_wide = 1'b0; m_run = 1'b0;
        m_wr = 1'b1; m_sel = 1'b1; m_wdata = 8'h40; cyc();
        m_wr = 1'b0;
        #0.5;
        chk("R10 high read", 32'(m_rdata), 32'h40);
        m_sel = 1'b0;
        #0.5;
        chk("R10 low read", 32'(m_rdata), 32'h00);

        // R11 synchronizer latency, single count per edge
        s_wide = 1'b1; s_run = 1'b1;
        s_src = 1'b1;
        cyc();
        chk("R11 edge+1", 32'(s_cnt), 32'h0);
        cyc();
        chk("R11 edge+2", 32'(s_cnt), 32'h0);
        cyc();
        chk("R11 edge+3", 32'(s_cnt), 32'h1);
        repeat (4) cyc();
        chk("R11 level held", 32'(s_cnt), 32'h1);
        s_src = 1'b0;
        repeat (3) cyc();
        s_edge();
        chk("R11 second edge", 32'(s_cnt), 32'h2);

        // R5 wrap through the synchronized path
        s_run = 1'b0;
        s_wr = 1'b1; s_sel = 1'b1; s_wdata = 4'hF; cyc();
        s_sel = 1'b0; s_wdata = 4'hE; cyc();
        s_wr = 1'b0;
        chk("R8 sync preload", 32'(s_cnt), 32'hFE);
        s_run = 1'b1;
        s_evt_seen = 0;
        s_edge();
        chk("R5 sync to max", 32'(s_cnt), 32'hFF);
        chk("R6 no event before wrap", 32'(s_evt_seen), 32'h0);
        s_edge();
        chk("R5 sync wrap", 32'(s_cnt), 32'h00);
        chk("R6 one wrap event", 32'(s_evt_seen), 32'h1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule